// File: doc/BRIEF.md
# Blocking Cache Miss and Writeback Holding Controller

This controller sits between a blocking cache and the memory bus. It owns two holding registers: one for a miss that is waiting to be serviced, and one for a write or writeback that is being pushed out to memory. Each register has its own blocked flag, which tells the cache to stall new traffic of that kind, and its own bus request. The controller also decides which register is presented to the bus.

A request from the cache is routed to one of the two registers according to its type and the write-allocate setting. A cache eviction always goes to the writeback register. Once the bus accepts an entry over a valid/ready handshake, the entry either retires immediately, if it expects no reply, or waits in service until its response arrives. The response completes the entry and forwards read data to the single waiting target.

A squash tagged with a thread number cancels the target of that thread's miss. If the miss has not yet been issued, the squash also releases it. Per-thread counters record every writeback accepted into the writeback register.

Top module: `blk_miss_buf`

## Requirements
- R1: The address presented on the bus for either entry is the allocating address with its low log2(BLK_BYTES) bits cleared.
- R2: A request with `req_write_i`=1 goes to the writeback entry when `req_uncache_i`=1, or `wr_alloc_en_i`=0, or `req_no_resp_i`=1. Every other request goes to the miss entry.
- R3: An accepted allocation sets that entry's blocked flag (`blk_mshr_o` for the miss entry, `blk_wb_o` for the writeback entry) and its request (`mreq_o` or `wbreq_o`) from the next cycle on. A request is never high while its blocked flag is low.
- R4: A miss with `req_uncache_i`=0 is presented with `bus_fill_o`=1. An uncacheable miss and every writeback entry are presented with `bus_fill_o`=0. `bus_write_o` equals the entry's write bit and is forced to 0 whenever `bus_fill_o`=1.
- R5: `bus_valid_o` is high whenever either entry is valid and not yet issued. `bus_src_o`=0 (miss) is chosen over `bus_src_o`=1 (writeback) whenever the miss entry is pending.
- R6: An entry is issued in a cycle where `bus_valid_o` and `bus_ready_i` are both high. Its request drops in the next cycle. If the entry expects no response, the entry is freed and its blocked flag drops in the next cycle. Otherwise it stays blocked and in service.
- R7: A response (`rsp_valid_i`, with `rsp_src_i` 0 = miss and 1 = writeback) to an in-service entry frees that entry and clears its blocked flag in the next cycle. A response to the miss entry whose target is still present raises `tgt_valid_o` in the same cycle, with the entry's thread on `tgt_thread_o`. `tgt_data_o` carries `rsp_data_i` for a read and zero for a write. A response to an entry that is empty or not in service has no effect.
- R8: A squash whose thread matches the miss entry's thread removes that entry's target. If the entry is not in service and is not being issued in the same cycle, the entry is also freed, and `blk_mshr_o` and `mreq_o` drop in the next cycle.
- R9: Each allocation accepted into the writeback entry increments the counter of its thread in `wb_cnt_o`, where thread t occupies bits [t*CNT_W +: CNT_W]. An eviction (`evict_i`) is charged to thread 0. It allocates the writeback entry as a write that expects no response and has the block-aligned `evict_addr_i`.
- R10: An allocation aimed at an occupied entry is ignored and sets the sticky flag `err_o`. When an eviction and a request bound for the writeback entry arrive together, the eviction wins, the request is dropped, and `err_o` is set.
- R11: Reset empties both entries, lowers every flag, request and bus output, and zeroes all counters and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request from the cache |
| req_addr_i | input | ADDR_W | Request byte address |
| req_write_i | input | 1 | Request is a write |
| req_uncache_i | input | 1 | Request is uncacheable |
| req_no_resp_i | input | 1 | Request expects no response |
| req_thread_i | input | THR_W | Thread of the request |
| wr_alloc_en_i | input | 1 | Write-allocate enabled |
| evict_i | input | 1 | Eviction writeback from the cache |
| evict_addr_i | input | ADDR_W | Eviction address |
| bus_valid_o | output | 1 | An entry is offered to the bus |
| bus_ready_i | input | 1 | Bus accepts the offered entry |
| bus_src_o | output | 1 | 0 miss entry, 1 writeback entry |
| bus_addr_o | output | ADDR_W | Block address of the offered entry |
| bus_write_o | output | 1 | Offered command is a write |
| bus_fill_o | output | 1 | Offered command is a line fill |
| bus_noresp_o | output | 1 | Offered command expects no response |
| rsp_valid_i | input | 1 | Bus response |
| rsp_src_i | input | 1 | Entry the response belongs to |
| rsp_data_i | input | DATA_W | Response data |
| tgt_valid_o | output | 1 | Response forwarded to the waiting target |
| tgt_thread_o | output | THR_W | Thread of that target |
| tgt_data_o | output | DATA_W | Forwarded read data |
| squash_i | input | 1 | Squash strobe |
| squash_thread_i | input | THR_W | Thread being squashed |
| blk_mshr_o | output | 1 | Miss entry occupied, cache blocked on misses |
| blk_wb_o | output | 1 | Writeback entry occupied, cache blocked on writebacks |
| mreq_o | output | 1 | Miss bus request |
| wbreq_o | output | 1 | Writeback bus request |
| wb_cnt_o | output | NUM_THR*CNT_W | Per-thread writeback counters |
| err_o | output | 1 | Sticky allocation-collision flag |

## Verification
The bench targets the cases where events coincide. A squash in the cycle the miss is accepted by the bus must leave the entry in service; a design that freed it would lose the response and drop `blk_mshr_o` too early. A squash together with a response must suppress `tgt_valid_o`; a design that got this wrong would complete a cancelled target. A second allocation into a busy entry must not overwrite it. An overwrite would show up as a changed `bus_addr_o` while `err_o` stayed low. An eviction that collides with a writeback-bound request must win and charge thread 0. A wrong routing rule or missing write-allocate decode appears as the wrong blocked flag rising. A forgotten fill override appears as `bus_write_o` high on a write-allocate fill.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;
  typedef struct packed {
    logic write;
    logic no_resp;
    logic fill;
    logic has_tgt;
  } mb_flags_t;

  typedef enum logic {SRC_MISS = 1'b0, SRC_WB = 1'b1} mb_src_e;
endpackage

// File: rtl/mbuf_route.sv
module mbuf_route
  import mbuf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int THR_W     = 2,
  parameter int BLK_BYTES = 64
) (
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_uncache_i,
  input  logic              req_no_resp_i,
  input  logic [THR_W-1:0]  req_thread_i,
  input  logic              wr_alloc_en_i,
  input  logic              evict_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  output logic              alloc_miss_o,
  output logic              alloc_wb_o,
  output logic              collide_o,
  output logic [ADDR_W-1:0] miss_addr_o,
  output mb_flags_t         miss_flags_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [THR_W-1:0]  wb_thr_o,
  output mb_flags_t         wb_flags_o
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

  logic to_wb;
  logic [ADDR_W-1:0] req_blk;

  assign to_wb   = req_write_i & (req_uncache_i | ~wr_alloc_en_i | req_no_resp_i);
  assign req_blk = req_addr_i & BLK_MASK;

  assign alloc_miss_o = req_valid_i & ~to_wb;
  assign alloc_wb_o   = evict_i | (req_valid_i & to_wb);
  assign collide_o    = evict_i & req_valid_i & to_wb;

  assign miss_addr_o          = req_blk;
  assign miss_flags_o.write   = req_write_i;
  assign miss_flags_o.no_resp = req_no_resp_i;
  assign miss_flags_o.fill    = ~req_uncache_i;
  assign miss_flags_o.has_tgt = ~req_no_resp_i;

  // eviction: thread 0, fire-and-forget write
  always_comb begin
    if (evict_i) begin
      wb_addr_o  = evict_addr_i & BLK_MASK;
      wb_thr_o   = '0;
      wb_flags_o = '{write: 1'b1, no_resp: 1'b1, fill: 1'b0, has_tgt: 1'b0};
    end else begin
      wb_addr_o  = req_blk;
      wb_thr_o   = req_thread_i;
      wb_flags_o = '{write: req_write_i, no_resp: req_no_resp_i, fill: 1'b0,
                     has_tgt: ~req_no_resp_i};
    end
  end
endmodule

// File: rtl/mbuf_entry.sv
module mbuf_entry
  import mbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int THR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [THR_W-1:0]  ld_thr_i,
  input  mb_flags_t         ld_flags_i,
  input  logic              issue_i,
  input  logic              free_i,
  input  logic              drop_tgt_i,
  output logic              valid_o,
  output logic              insvc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [THR_W-1:0]  thr_o,
  output mb_flags_t         flags_o
);
  logic              valid_q, insvc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [THR_W-1:0]  thr_q;
  mb_flags_t         flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      insvc_q <= 1'b0;
      addr_q  <= '0;
      thr_q   <= '0;
      flags_q <= '0;
    end else begin
      if (free_i) begin
        valid_q <= 1'b0;
        insvc_q <= 1'b0;
      end else if (alloc_i && !valid_q) begin
        valid_q <= 1'b1;
        insvc_q <= 1'b0;
        addr_q  <= ld_addr_i;
        thr_q   <= ld_thr_i;
        flags_q <= ld_flags_i;
      end else if (issue_i) begin
        if (flags_q.no_resp) valid_q <= 1'b0;
        else                 insvc_q <= 1'b1;
      end
      if (drop_tgt_i) flags_q.has_tgt <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign insvc_o = insvc_q;
  assign addr_o  = addr_q;
  assign thr_o   = thr_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/mbuf_wbcnt.sv
module mbuf_wbcnt #(
  parameter int NUM_THR = 4,
  parameter int THR_W   = 2,
  parameter int CNT_W   = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     inc_i,
  input  logic [THR_W-1:0]         thr_i,
  output logic [NUM_THR*CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < NUM_THR; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt_q <= '0;
      else if (inc_i && (thr_i == THR_W'(g)))     cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/blk_miss_buf.sv
module blk_miss_buf
  import mbuf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int NUM_THR   = 4,
  parameter int CNT_W     = 16,
  localparam int THR_W    = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic                     req_write_i,
  input  logic                     req_uncache_i,
  input  logic                     req_no_resp_i,
  input  logic [THR_W-1:0]         req_thread_i,
  input  logic                     wr_alloc_en_i,
  input  logic                     evict_i,
  input  logic [ADDR_W-1:0]        evict_addr_i,
  output logic                     bus_valid_o,
  input  logic                     bus_ready_i,
  output logic                     bus_src_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic                     bus_write_o,
  output logic                     bus_fill_o,
  output logic                     bus_noresp_o,
  input  logic                     rsp_valid_i,
  input  logic                     rsp_src_i,
  input  logic [DATA_W-1:0]        rsp_data_i,
  output logic                     tgt_valid_o,
  output logic [THR_W-1:0]         tgt_thread_o,
  output logic [DATA_W-1:0]        tgt_data_o,
  input  logic                     squash_i,
  input  logic [THR_W-1:0]         squash_thread_i,
  output logic                     blk_mshr_o,
  output logic                     blk_wb_o,
  output logic                     mreq_o,
  output logic                     wbreq_o,
  output logic [NUM_THR*CNT_W-1:0] wb_cnt_o,
  output logic                     err_o
);
  logic alloc_miss, alloc_wb, collide;
  logic [ADDR_W-1:0] ld_miss_addr, ld_wb_addr;
  logic [THR_W-1:0]  ld_wb_thr;
  mb_flags_t         ld_miss_flags, ld_wb_flags;

  logic m_valid, m_insvc, w_valid, w_insvc;
  logic [ADDR_W-1:0] m_addr, w_addr;
  logic [THR_W-1:0]  m_thr, w_thr;
  mb_flags_t         m_flags, w_flags;

  logic sel_miss, sel_wb, fire_m, fire_w;
  logic sq_hit, rsp_m, rsp_w, free_m, free_w;
  logic err_q;

  mbuf_route #(.ADDR_W(ADDR_W), .THR_W(THR_W), .BLK_BYTES(BLK_BYTES)) u_route (
    .req_valid_i, .req_addr_i, .req_write_i, .req_uncache_i, .req_no_resp_i,
    .req_thread_i, .wr_alloc_en_i, .evict_i, .evict_addr_i,
    .alloc_miss_o(alloc_miss), .alloc_wb_o(alloc_wb), .collide_o(collide),
    .miss_addr_o(ld_miss_addr), .miss_flags_o(ld_miss_flags),
    .wb_addr_o(ld_wb_addr), .wb_thr_o(ld_wb_thr), .wb_flags_o(ld_wb_flags)
  );

  // arbitration: pending miss beats writeback
  assign sel_miss = m_valid & ~m_insvc;
  assign sel_wb   = ~sel_miss & w_valid & ~w_insvc;
  assign fire_m   = sel_miss & bus_ready_i;
  assign fire_w   = sel_wb & bus_ready_i;

  assign sq_hit = squash_i & m_valid & (m_thr == squash_thread_i);
  assign rsp_m  = rsp_valid_i & (rsp_src_i == SRC_MISS) & m_valid & m_insvc;
  assign rsp_w  = rsp_valid_i & (rsp_src_i == SRC_WB) & w_valid & w_insvc;
  // an entry being issued this cycle is treated as already in service
  assign free_m = rsp_m | (sq_hit & ~m_insvc & ~fire_m);
  assign free_w = rsp_w;

  mbuf_entry #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_miss (
    .clk_i, .rst_ni,
    .alloc_i(alloc_miss), .ld_addr_i(ld_miss_addr), .ld_thr_i(req_thread_i),
    .ld_flags_i(ld_miss_flags), .issue_i(fire_m), .free_i(free_m),
    .drop_tgt_i(sq_hit),
    .valid_o(m_valid), .insvc_o(m_insvc), .addr_o(m_addr), .thr_o(m_thr),
    .flags_o(m_flags)
  );

  mbuf_entry #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_wb (
    .clk_i, .rst_ni,
    .alloc_i(alloc_wb), .ld_addr_i(ld_wb_addr), .ld_thr_i(ld_wb_thr),
    .ld_flags_i(ld_wb_flags), .issue_i(fire_w), .free_i(free_w),
    .drop_tgt_i(1'b0),
    .valid_o(w_valid), .insvc_o(w_insvc), .addr_o(w_addr), .thr_o(w_thr),
    .flags_o(w_flags)
  );

  mbuf_wbcnt #(.NUM_THR(NUM_THR), .THR_W(THR_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(alloc_wb & ~w_valid), .thr_i(ld_wb_thr),
    .cnt_o(wb_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if ((alloc_miss & m_valid) | (alloc_wb & w_valid) | collide) err_q <= 1'b1;
  end

  assign bus_valid_o  = sel_miss | sel_wb;
  assign bus_src_o    = sel_wb;
  assign bus_addr_o   = sel_wb ? w_addr : m_addr;
  assign bus_fill_o   = sel_wb ? w_flags.fill : m_flags.fill;
  assign bus_write_o  = sel_wb ? w_flags.write : (m_flags.write & ~m_flags.fill);
  assign bus_noresp_o = sel_wb ? w_flags.no_resp : m_flags.no_resp;

  assign tgt_valid_o  = rsp_m & m_flags.has_tgt & ~sq_hit;
  assign tgt_thread_o = m_thr;
  assign tgt_data_o   = m_flags.write ? '0 : rsp_data_i;

  assign blk_mshr_o = m_valid;
  assign blk_wb_o   = w_valid;
  assign mreq_o     = m_valid & ~m_insvc;
  assign wbreq_o    = w_valid & ~w_insvc;
  assign err_o      = err_q;

  // w_thr is held for completeness of the entry; only the miss thread is observed
  logic unused_w_thr;
  assign unused_w_thr = ^w_thr;
endmodule

// File: rtl/mbuf_chk.sv
module mbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_valid_o,
  input logic bus_ready_i,
  input logic bus_src_o,
  input logic bus_fill_o,
  input logic bus_write_o,
  input logic mreq_o,
  input logic wbreq_o,
  input logic blk_mshr_o,
  input logic blk_wb_o,
  input logic err_o,
  input logic tgt_valid_o,
  input logic rsp_valid_i,
  input logic rsp_src_i
);
  assert_req_implies_blk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_o |-> blk_mshr_o) and (wbreq_o |-> blk_wb_o));

  assert_fill_not_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_fill_o) |-> !bus_write_o);

  assert_miss_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && mreq_o) |-> !bus_src_o);

  assert_miss_req_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i && !bus_src_o) |=> !mreq_o);

  assert_wb_req_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && bus_ready_i && bus_src_o) |=> !wbreq_o);

  assert_tgt_on_rsp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> (rsp_valid_i && !rsp_src_i));

  assert_rsp_frees_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |=> !blk_mshr_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind blk_miss_buf mbuf_chk u_chk (.*);

// File: tb/sim_blk_miss_buf.sv
module sim_blk_miss_buf;
  localparam int ADDR_W = 32, DATA_W = 32, BLK_BYTES = 64, NUM_THR = 4, CNT_W = 16;
  localparam int THR_W = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic rv, wr, unc, nr, wa, ev, rdy, rspv, rsps, sq;
  logic [ADDR_W-1:0] addr, eaddr;
  logic [THR_W-1:0] thr, sqthr;
  logic [DATA_W-1:0] rspd;

  logic bus_valid, bus_src, bus_write, bus_fill, bus_noresp, tgt_valid;
  logic [ADDR_W-1:0] bus_addr;
  logic [THR_W-1:0] tgt_thr;
  logic [DATA_W-1:0] tgt_data;
  logic blk_m, blk_w, mreq, wbreq, err;
  logic [NUM_THR*CNT_W-1:0] wb_cnt;

  blk_miss_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES),
                 .NUM_THR(NUM_THR), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_addr_i(addr),
    .req_write_i(wr), .req_uncache_i(unc), .req_no_resp_i(nr), .req_thread_i(thr),
    .wr_alloc_en_i(wa), .evict_i(ev), .evict_addr_i(eaddr),
    .bus_valid_o(bus_valid), .bus_ready_i(rdy), .bus_src_o(bus_src),
    .bus_addr_o(bus_addr), .bus_write_o(bus_write), .bus_fill_o(bus_fill),
    .bus_noresp_o(bus_noresp), .rsp_valid_i(rspv), .rsp_src_i(rsps),
    .rsp_data_i(rspd), .tgt_valid_o(tgt_valid), .tgt_thread_o(tgt_thr),
    .tgt_data_o(tgt_data), .squash_i(sq), .squash_thread_i(sqthr),
    .blk_mshr_o(blk_m), .blk_wb_o(blk_w), .mreq_o(mreq), .wbreq_o(wbreq),
    .wb_cnt_o(wb_cnt), .err_o(err)
  );

  int errs = 0, checks = 0;

  // reference model state
  bit mv, mi, mw, mn, mf, mt;  logic [ADDR_W-1:0] ma;  int mth;
  bit wv, wi, ww, wn, wt;      logic [ADDR_W-1:0] wa_q;
  int cnt[NUM_THR];
  bit merr;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    rv = 0; addr = '0; wr = 0; unc = 0; nr = 0; thr = '0; ev = 0; eaddr = '0;
    rdy = 0; rspv = 0; rsps = 0; rspd = '0; sq = 0; sqthr = '0;
  endtask

  task automatic model_reset();
    mv = 0; mi = 0; mw = 0; mn = 0; mf = 0; mt = 0; ma = '0; mth = 0;
    wv = 0; wi = 0; ww = 0; wn = 0; wt = 0; wa_q = '0;
    foreach (cnt[k]) cnt[k] = 0;
    merr = 0;
  endtask

  // one clock: compare outputs for current inputs, then advance model
  task automatic cyc();
    bit sm, sw, to_wb, amiss, awb, coll, sqh, rm, rw, fm, fw, freem;
    logic [ADDR_W-1:0] blk;
    logic [NUM_THR*CNT_W-1:0] ecnt;
    #1;
    sm = mv && !mi;
    sw = !sm && wv && !wi;
    to_wb = wr && (unc || !wa || nr);
    amiss = rv && !to_wb;
    awb = ev || (rv && to_wb);
    coll = ev && rv && to_wb;
    sqh = sq && mv && (mth == int'(sqthr));
    rm = rspv && !rsps && mv && mi;
    rw = rspv && rsps && wv && wi;
    blk = addr & ~ADDR_W'(BLK_BYTES - 1);

    chk("R5", "bus_valid", bus_valid, sm || sw);
    if (sm || sw) begin
      chk("R5", "bus_src", bus_src, sw);
      chk("R1", "bus_addr", bus_addr, sw ? wa_q : ma);
      chk("R4", "bus_fill", bus_fill, sw ? 1'b0 : mf);
      chk("R4", "bus_write", bus_write, sw ? ww : (mw && !mf));
      chk("R6", "bus_noresp", bus_noresp, sw ? wn : mn);
    end
    chk("R3", "blk_mshr", blk_m, mv);
    chk("R3", "blk_wb", blk_w, wv);
    chk("R3", "mreq", mreq, mv && !mi);
    chk("R3", "wbreq", wbreq, wv && !wi);
    chk("R10", "err", err, merr);
    chk("R7", "tgt_valid", tgt_valid, rm && mt && !sqh);
    if (rm && mt && !sqh) begin
      chk("R7", "tgt_thread", tgt_thr, mth);
      chk("R7", "tgt_data", tgt_data, mw ? '0 : rspd);
    end
    for (int k = 0; k < NUM_THR; k++) ecnt[k*CNT_W +: CNT_W] = CNT_W'(cnt[k]);
    chk("R9", "wb_cnt", wb_cnt, ecnt);

    fm = sm && rdy;
    fw = sw && rdy;
    freem = rm || (sqh && !mi && !fm);
    if (coll || (amiss && mv) || (awb && wv)) merr = 1;
    if (awb && !wv) begin
      if (ev) cnt[0] = (cnt[0] + 1) % (1 << CNT_W);
      else    cnt[thr] = (cnt[thr] + 1) % (1 << CNT_W);
    end
    if (freem) begin mv = 0; mi = 0; end
    else if (amiss && !mv) begin
      mv = 1; mi = 0; ma = blk; mw = wr; mn = nr; mf = !unc; mt = !nr; mth = thr;
    end else if (fm) begin
      if (mn) mv = 0; else mi = 1;
    end
    if (sqh) mt = 0;
    if (rw) begin wv = 0; wi = 0; end
    else if (awb && !wv) begin
      wv = 1; wi = 0;
      if (ev) begin wa_q = eaddr & ~ADDR_W'(BLK_BYTES - 1); ww = 1; wn = 1; wt = 0; end
      else    begin wa_q = blk; ww = wr; wn = nr; wt = !nr; end
    end else if (fw) begin
      if (wn) wv = 0; else wi = 1;
    end
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(); wa = 1; rst_n = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk("R11", "reset blk_mshr", blk_m, 0);
    chk("R11", "reset blk_wb", blk_w, 0);
    chk("R11", "reset bus_valid", bus_valid, 0);
    chk("R11", "reset err", err, 0);
    chk("R11", "reset wb_cnt", wb_cnt, '0);

    // cacheable read miss, thread 1
    rv = 1; addr = 32'h1234_5678; thr = 1; cyc();
    chk("R2", "read to miss entry", {blk_m, blk_w}, 2'b10);
    chk("R1", "masked addr", bus_addr, 32'h1234_5640);
    chk("R4", "fill on cacheable", bus_fill, 1);
    // uncacheable write, thread 2, goes to wb
    rv = 1; wr = 1; unc = 1; addr = 32'h0000_0104; thr = 2; cyc();
    chk("R2", "uncacheable write to wb", blk_w, 1);
    chk("R5", "miss presented first", bus_src, 0);
    // issue the miss
    rdy = 1; cyc();
    chk("R6", "miss req drops, still blocked", {mreq, blk_m}, 2'b01);
    chk("R5", "wb now presented", {bus_valid, bus_src}, 2'b11);
    rdy = 1; cyc();
    chk("R6", "wb in service", {wbreq, blk_w}, 2'b01);
    rspv = 1; rsps = 0; rspd = 32'hDEAD_BEEF; cyc();
    chk("R7", "miss freed on response", blk_m, 0);
    rspv = 1; rsps = 1; cyc();
    chk("R7", "wb freed on response", blk_w, 0);
    // squash before issue
    rv = 1; addr = 32'h40; thr = 3; cyc();
    sq = 1; sqthr = 3; cyc();
    chk("R8", "squash frees pending miss", {blk_m, mreq}, 2'b00);
    // squash in issue cycle keeps entry, then response yields no target
    rv = 1; addr = 32'h80; thr = 1; cyc();
    rdy = 1; sq = 1; sqthr = 1; cyc();
    chk("R8", "issued miss survives squash", blk_m, 1);
    rspv = 1; rsps = 0; rspd = 32'h1111_2222; cyc();
    chk("R8", "squashed target not completed", blk_m, 0);
    // write-allocate write miss: fill, bus command not a write
    rv = 1; wr = 1; addr = 32'h200; thr = 2; cyc();
    chk("R4", "fill masks write", {bus_fill, bus_write}, 2'b10);
    rdy = 1; cyc();
    rspv = 1; rsps = 0; rspd = 32'hFFFF_FFFF; #1;
    chk("R7", "write target gets zero data", tgt_data, 0);
    cyc();
    // eviction charged to thread 0, freed on issue
    ev = 1; eaddr = 32'h0000_0FFF; cyc();
    chk("R9", "evict counts thread 0", wb_cnt[CNT_W-1:0], 1);
    rdy = 1; cyc();
    chk("R6", "no-response entry freed on issue", blk_w, 0);
    // collision on occupied miss entry
    rv = 1; addr = 32'h300; cyc();
    rv = 1; addr = 32'h500; cyc();
    chk("R10", "occupied entry kept", bus_addr, 32'h300);
    chk("R10", "err set", err, 1);
    // eviction with a wb-bound request in the same cycle
    rdy = 1; cyc();
    rspv = 1; cyc();
    ev = 1; eaddr = 32'h700; rv = 1; wr = 1; nr = 1; thr = 3; addr = 32'h900; cyc();
    chk("R10", "eviction wins collision", bus_addr, 32'h700);

    for (int n = 0; n < 4000; n++) begin
      rv = ($urandom % 3) == 0; addr = $urandom; wr = $urandom % 2;
      unc = ($urandom % 3) == 0; nr = ($urandom % 4) == 0; thr = THR_W'($urandom);
      wa = ($urandom % 4) != 0; ev = ($urandom % 8) == 0; eaddr = $urandom;
      rdy = $urandom % 2; rspv = ($urandom % 3) == 0; rsps = $urandom % 2;
      rspd = $urandom; sq = ($urandom % 10) == 0; sqthr = THR_W'($urandom);
      cyc();
    end
    summary();
    $finish;
  end
endmodule